// File: doc/BRIEF.md
# Flow-Through Synchronous Static Memory with Byte-Lane Writes

This block is a single-port synchronous memory for on-chip use. On each rising clock edge it captures the address, the write data, three chip selects and the write controls. A write goes into the array at that same edge. A read returns the addressed word during the cycle that follows the edge. The read path goes straight from the array through a multiplexer to the outputs, with no output register. The word is split into byte lanes of nine bits each. The lanes to write come either from a global write, which writes every lane, or from a byte-write enable combined with one select per lane.

The data bus is modelled as a separate input and output with a drive flag. "Floating" outputs mean that the drive flag is low and the output word reads as zero. The output enable acts on the outputs combinationally. A sleep input blocks all accesses and leaves the stored contents unchanged.

Top module: `fts_sram`

## Requirements
- R1: After reset is released, `dqDrive` is low and `dqOut` is zero until the first read cycle.
- R2: A read is captured at an edge when the block is selected, sleep is low and no lane is selected for writing. In the following cycle, `dqDrive` is high and `dqOut` equals the stored word at the captured address, provided `outEnN` and `sleep` are low.
- R3: With `globalWrN` low at a selected edge, all lanes of the addressed word take `dqIn`, whatever the values of `byteWrEnN` and `laneWrN`.
- R4: With `globalWrN` high and `byteWrEnN` low, lane i is written exactly when `laneWrN[i]` is low, and the other lanes keep their contents. Lane i occupies bits [9i+8:9i].
- R5: With `globalWrN` and `byteWrEnN` both high, nothing is written and the edge is a read, whatever the value of `laneWrN`.
- R6: The block is selected only when `ceAN`=0, `ceB`=1 and `ceCN`=0. An edge without selection writes nothing, and the outputs float for the cycle that follows.
- R7: While `outEnN` is high, the outputs float, with no clock edge needed.
- R8: For the cycle after a write edge, the outputs float.
- R9: With `sleep` high at an edge, nothing is written and the outputs float. While `sleep` is high, the outputs float.
- R10: Whenever `dqDrive` is low, `dqOut` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset of control state |
| addrIn | input | ADDR_W | Word address |
| dqIn | input | LANES*LANE_W | Write data |
| ceAN | input | 1 | Chip select, active low |
| ceB | input | 1 | Chip select, active high |
| ceCN | input | 1 | Chip select, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Enables per-lane writes, active low |
| laneWrN | input | LANES | Per-lane write selects, active low |
| outEnN | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Low-power hold, active high |
| dqOut | output | LANES*LANE_W | Read data, zero when floating |
| dqDrive | output | 1 | High when outputs are driven |

## Verification
The write logic is tried with a global write whose lane inputs contradict it, with byte writes that pick alternating lanes and a single top lane, and with lane selects that are set while the byte-write enable is off. Each of these is read back, so a mistake in the lane mask or in its priority shows up in specific lanes of the word. Each chip select is deasserted on its own during an attempted write. A later read of the untouched word then shows whether that select alone gates the access. The output enable is toggled between clock edges, and sleep is held during a write. These show that floating outputs and blocked writes come from the right source.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic capture;   // latch address for a read cycle
    logic doWrite;   // commit masked lanes at this edge
    logic driveOut;  // present array word on the outputs
  } strobe_t;
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceAN,
  input  logic             ceB,
  input  logic             ceCN,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] laneWrN,
  input  logic             outEnN,
  input  logic             sleep,
  output logic [LANES-1:0] laneMask,
  output fts_pkg::strobe_t stb
);
  logic selNow;
  logic active;
  logic anyLane;
  logic readCycle;

  assign selNow = ~ceAN & ceB & ~ceCN;
  assign active = selNow & ~sleep;

  // Global write overrides; otherwise byte-write enable gates lane selects
  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign laneMask[l] = ~globalWrN | (~byteWrEnN & ~laneWrN[l]);
  end

  assign anyLane = |laneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readCycle <= 1'b0;
    else       readCycle <= active & ~anyLane;
  end

  always_comb begin
    stb.capture  = active & ~anyLane;
    stb.doWrite  = active & anyLane;
    stb.driveOut = readCycle & ~outEnN & ~sleep;
  end
endmodule

// File: rtl/fts_datapath.sv
module fts_datapath #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dqIn,
  input  logic [LANES-1:0]        laneMask,
  input  fts_pkg::strobe_t        stb,
  output logic [LANES*LANE_W-1:0] dqOut
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            addrReg <= '0;
    else if (stb.capture) addrReg <= addrIn;
  end

  // Lane-masked write committed at the capturing edge
  always_ff @(posedge clk) begin
    if (stb.doWrite) begin
      for (int l = 0; l < LANES; l++) begin
        if (laneMask[l]) mem[addrIn][l*LANE_W +: LANE_W] <= dqIn[l*LANE_W +: LANE_W];
      end
    end
  end

  // Flow-through read: no output register
  assign dqOut = stb.driveOut ? mem[addrReg] : '0;
endmodule

// File: rtl/fts_sram.sv
module fts_sram #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dqIn,
  input  logic                    ceAN,
  input  logic                    ceB,
  input  logic                    ceCN,
  input  logic                    globalWrN,
  input  logic                    byteWrEnN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    outEnN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqDrive
);
  fts_pkg::strobe_t stb;
  logic [LANES-1:0] laneMask;

  fts_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceAN(ceAN), .ceB(ceB), .ceCN(ceCN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .outEnN(outEnN), .sleep(sleep), .laneMask(laneMask), .stb(stb)
  );

  fts_datapath #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dqIn(dqIn),
    .laneMask(laneMask), .stb(stb), .dqOut(dqOut)
  );

  assign dqDrive = stb.driveOut;
endmodule

// File: rtl/fts_sram_checker.sv
module fts_sram_checker #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    ceAN,
  input logic                    ceB,
  input logic                    ceCN,
  input logic                    globalWrN,
  input logic                    byteWrEnN,
  input logic [LANES-1:0]        laneWrN,
  input logic                    outEnN,
  input logic                    sleep,
  input logic [LANES*LANE_W-1:0] dqOut,
  input logic                    dqDrive
);
  logic sel;
  logic wantsWrite;
  assign sel        = ~ceAN & ceB & ~ceCN;
  assign wantsWrite = ~globalWrN | (~byteWrEnN & ~(&laneWrN));

  assert_float_after_deselect_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> !dqDrive);

  assert_float_after_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !sleep && wantsWrite) |=> !dqDrive);

  assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !dqDrive);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !sleep && !wantsWrite) |=> (dqDrive || outEnN || sleep));

  assert_oe_floats_R7: assert property (@(negedge clk) disable iff (!rstN)
    outEnN |-> !dqDrive);

  assert_zero_when_float_R10: assert property (@(negedge clk) disable iff (!rstN)
    !dqDrive |-> (dqOut == '0));
endmodule

bind fts_sram fts_sram_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_fts_sram.sv
module tb_fts_sram;
  localparam int LANES = 4, LANE_W = 9, ADDR_W = 4;
  localparam int DW = LANES * LANE_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DW-1:0] dqIn = '0;
  logic ceAN = 1'b1, ceB = 1'b0, ceCN = 1'b1;
  logic globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [LANES-1:0] laneWrN = '1;
  logic outEnN = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dqOut;
  logic dqDrive;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fts_sram #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) dut (.*);

  typedef struct packed {
    logic        sel;
    logic        gwN;
    logic        bweN;
    logic [3:0]  lanesN;
    logic [3:0]  addr;
    logic [35:0] data;
    logic        expDrive;
    logic [35:0] expData;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 4'b1111, 4'd1, 36'h123456789, 1'b0, 36'h0},         // R3 global write, lanes ignored
    '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd1, 36'h0,         1'b1, 36'h123456789}, // R2 read back
    '{1'b1, 1'b1, 1'b0, 4'b1010, 4'd1, 36'hFFFFFFFFF, 1'b0, 36'h0},         // R4 lanes 0 and 2
    '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd1, 36'h0,         1'b1, 36'h127FD67FF}, // R4 read back
    '{1'b1, 1'b1, 1'b1, 4'b0000, 4'd1, 36'h0,         1'b1, 36'h127FD67FF}, // R5 lanes without enable
    '{1'b1, 1'b0, 1'b1, 4'b1111, 4'd2, 36'hABCDEF012, 1'b0, 36'h0},         // R3/R8
    '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd2, 36'h0,         1'b1, 36'hABCDEF012}, // R2
    '{1'b0, 1'b0, 1'b1, 4'b1111, 4'd2, 36'h0,         1'b0, 36'h0},         // R6 deselected write
    '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd2, 36'h0,         1'b1, 36'hABCDEF012}, // R6 untouched
    '{1'b1, 1'b1, 1'b1, 4'b1111, 4'd1, 36'h0,         1'b1, 36'h127FD67FF}  // R2 revisit
  };

  task automatic check(string req, logic actDrv, logic [DW-1:0] actData,
                       logic expDrv, logic [DW-1:0] expData);
    nChk++;
    if (actDrv !== expDrv || actData !== expData) begin
      nBad++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               req, actDrv, actData, expDrv, expData);
    end
  endtask

  // Drive one access at a falling edge, then wait to the next falling edge
  task automatic access(logic s, logic gw, logic bwe, logic [LANES-1:0] ln,
                        logic [ADDR_W-1:0] a, logic [DW-1:0] d);
    ceAN = ~s; ceB = s; ceCN = ~s;
    globalWrN = gw; byteWrEnN = bwe; laneWrN = ln; addrIn = a; dqIn = d;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nChk++; nBad++;
    $display("FAIL watchdog: run did not finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", dqDrive, dqOut, 1'b0, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", dqDrive, dqOut, 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].sel, VECS[i].gwN, VECS[i].bweN, VECS[i].lanesN, VECS[i].addr, VECS[i].data);
      check($sformatf("R2-table vector %0d", i), dqDrive, dqOut, VECS[i].expDrive, VECS[i].expData);
    end

    // R4: single top lane
    access(1, 0, 1, 4'b1111, 4'd3, 36'h0);
    check("R8 write floats", dqDrive, dqOut, 1'b0, '0);
    access(1, 1, 0, 4'b0111, 4'd3, 36'hFFFFFFFFF);
    access(1, 1, 1, 4'b1111, 4'd3, 36'h0);
    check("R4 lane 3 only", dqDrive, dqOut, 1'b1, 36'hFF8000000);

    // R6: each chip select on its own blocks the write
    for (int k = 0; k < 3; k++) begin
      ceAN = (k == 0); ceB = (k != 1); ceCN = (k == 2);
      globalWrN = 0; byteWrEnN = 1; laneWrN = '1; addrIn = 4'd2; dqIn = 36'h0;
      @(negedge clk);
      check($sformatf("R6 deselect by select %0d", k), dqDrive, dqOut, 1'b0, '0);
      access(1, 1, 1, 4'b1111, 4'd2, 36'h0);
      check("R6 contents kept", dqDrive, dqOut, 1'b1, 36'hABCDEF012);
    end

    // R7/R10: output enable between edges
    outEnN = 1'b1; #1;
    check("R7 oe high floats", dqDrive, dqOut, 1'b0, '0);
    check("R10 zero when floating", {1'b0}, dqOut, 1'b0, '0);
    outEnN = 1'b0; #1;
    check("R7 oe low drives again", dqDrive, dqOut, 1'b1, 36'hABCDEF012);

    // R9: sleep
    access(1, 0, 1, 4'b1111, 4'd4, 36'h111111111);
    sleep = 1'b1;
    access(1, 0, 1, 4'b1111, 4'd4, 36'h222222222);
    check("R9 sleep write floats", dqDrive, dqOut, 1'b0, '0);
    access(1, 1, 1, 4'b1111, 4'd4, 36'h0);
    check("R9 sleep read floats", dqDrive, dqOut, 1'b0, '0);
    sleep = 1'b0;
    access(1, 1, 1, 4'b1111, 4'd4, 36'h0);
    check("R9 contents kept", dqDrive, dqOut, 1'b1, 36'h111111111);
    sleep = 1'b1; #1;
    check("R9 sleep floats at once", dqDrive, dqOut, 1'b0, '0);
    sleep = 1'b0;

    finishRun();
  end
endmodule